// File: doc/BRIEF.md
# Bridge Command Register and Request Gate

This block keeps the writable low bits of a bridge port's command register and uses them to steer traffic. Upstream requests (memory, I/O and peer reads and writes, plus message-signalled interrupt writes) enter on a valid/ready interface. They leave on a second valid/ready interface through one register stage. While bus mastering is enabled, each request passes through unchanged. While it is disabled, a request is not dropped. A write is sent to a fixed harmless address with every byte enable cleared. A read is sent to the same address and marked so that its completion reports Unsupported Request.

Downstream, the block turns window-hit inputs from the address decoders into claim outputs. A memory claim is gated by the memory enable bit and an I/O claim by the I/O enable bit. A parity-response bit gates the request that sets the master data parity error status. A configuration port writes the register and reads it back. Byte lane 0 is the only lane that changes it.

Back-pressure rules: `up_in_ready` is high whenever the output stage is empty or is being drained in the same cycle. A request is accepted in a cycle where `up_in_valid` and `up_in_ready` are both high, and its classification is fixed at that moment. While `up_out_valid` is high and `up_out_ready` is low, every output field holds. No request is lost or reordered.

Top module: `bridge_cmd_gate`

## Requirements
- R1: After reset the configuration read value is 0, `up_out_valid` is 0 and both claim outputs are 0.
- R2: A configuration write with byte enable bit 0 set loads register bits 0 (I/O enable), 1 (memory enable), 2 (bus master enable) and 6 (parity response enable) from the write data. A write with byte enable bit 0 clear leaves the register unchanged.
- R3: Read-back bits 3, 4 and 5, and every bit above 6, always read 0 whatever was written.
- R4: `perr_set` is high only when `perr_detect` is high and bit 6 is 1; with bit 6 at 0 a detected error never raises it.
- R5: With bit 2 set at acceptance, the request leaves with kind, address, byte enables, data and tag unchanged and `up_out_ur` at 0. Kind codes are 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 interrupt message write, 5 peer read, 6 peer write.
- R6: With bit 2 clear at acceptance, a write (kind 1, 3, 4 or 6) leaves as kind 1 at address 0xC0000 with byte enables 0 and `up_out_ur` 0; data and tag are kept.
- R7: With bit 2 clear at acceptance, a read (any other kind) leaves as kind 0 at address 0xC0000 with `up_out_ur` 1; byte enables, data and tag are kept.
- R8: `dn_mem_claim` equals (`dn_mem_hit` or `dn_pmem_hit`) and bit 1; with bit 1 at 0 no memory claim is made.
- R9: `dn_io_claim` equals `dn_io_hit` and bit 0; with bit 0 at 0 no I/O claim is made.
- R10: A configuration write in the same cycle as an acceptance does not change that request's treatment; it applies from the next accepted request.
- R11: A request appears at the output the cycle after acceptance. It holds all its fields while `up_out_ready` is low, and requests leave in acceptance order without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | CFG_W/8 | Configuration byte enables |
| cfg_wdata | input | CFG_W | Configuration write data |
| cfg_rdata | output | CFG_W | Command register read value |
| up_in_valid | input | 1 | Upstream request valid |
| up_in_ready | output | 1 | Upstream request ready |
| up_in_kind | input | 3 | Request kind code |
| up_in_addr | input | ADDR_W | Request address |
| up_in_be | input | DATA_W/8 | Request byte enables |
| up_in_data | input | DATA_W | Request write data |
| up_in_tag | input | TAG_W | Request tag |
| up_out_valid | output | 1 | Forwarded request valid |
| up_out_ready | input | 1 | Forwarded request ready |
| up_out_kind | output | 3 | Forwarded kind |
| up_out_addr | output | ADDR_W | Forwarded address |
| up_out_be | output | DATA_W/8 | Forwarded byte enables |
| up_out_data | output | DATA_W | Forwarded data |
| up_out_tag | output | TAG_W | Forwarded tag |
| up_out_ur | output | 1 | Completion must report Unsupported Request |
| perr_detect | input | 1 | Master data parity error seen |
| perr_set | output | 1 | Request to set the parity status bit |
| dn_mem_hit | input | 1 | Downstream access hits the memory window |
| dn_pmem_hit | input | 1 | Downstream access hits the prefetchable window |
| dn_io_hit | input | 1 | Downstream access hits the I/O window |
| dn_mem_claim | output | 1 | Memory access claimed |
| dn_io_claim | output | 1 | I/O access claimed |

## Verification
A wrong register bit shows at the ports in the very next cycle. The read-back value differs, and the claim or parity outputs, which are combinational from the register, change at once. A wrong bus-master value shows the cycle after the next acceptance, as a request sent to the wrong address or with the wrong Unsupported Request mark. A fault in the output stage shows as a request that changes or vanishes while back-pressured, and the scoreboard catches it when that request is finally taken.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [2:0] {
    K_MEM_RD  = 3'd0,
    K_MEM_WR  = 3'd1,
    K_IO_RD   = 3'd2,
    K_IO_WR   = 3'd3,
    K_MSG_WR  = 3'd4,
    K_PEER_RD = 3'd5,
    K_PEER_WR = 3'd6
  } req_kind_e;

  localparam int CMD_BITS = 7;
  localparam int BIT_IOE  = 0;
  localparam int BIT_MEME = 1;
  localparam int BIT_BME  = 2;
  localparam int BIT_PERR = 6;
  localparam logic [CMD_BITS-1:0] CMD_WMASK = 7'b100_0111;

  typedef struct packed {
    logic perr_en;
    logic bm_en;
    logic mem_en;
    logic io_en;
  } cmd_bits_t;

  function automatic logic kind_is_write(logic [2:0] k);
    return (k == K_MEM_WR) || (k == K_IO_WR) || (k == K_MSG_WR) || (k == K_PEER_WR);
  endfunction
endpackage

// File: rtl/bcg_cmd_reg.sv
module bcg_cmd_reg
  import bcg_pkg::*;
#(
  parameter int CFG_W = 16,
  localparam int CBE_W = CFG_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CBE_W-1:0] cfg_be,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output cmd_bits_t        cmd_o
);
  logic [CMD_BITS-1:0] cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cfg_wr && cfg_be[0]) begin
      cmd_q <= cfg_wdata[CMD_BITS-1:0] & CMD_WMASK;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[CMD_BITS-1:0] = cmd_q;
  end

  assign cmd_o.perr_en = cmd_q[BIT_PERR];
  assign cmd_o.bm_en   = cmd_q[BIT_BME];
  assign cmd_o.mem_en  = cmd_q[BIT_MEME];
  assign cmd_o.io_en   = cmd_q[BIT_IOE];
endmodule

// File: rtl/bcg_up_gate.sv
module bcg_up_gate
  import bcg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  parameter logic [ADDR_W-1:0] SINK_ADDR = 'hC0000,
  localparam int DBE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bm_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DBE_W-1:0]  in_be,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DBE_W-1:0]  out_be,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_ur
);
  logic              accept;
  logic              is_wr;
  logic              keep_be;
  logic [2:0]        kind_n;
  logic [ADDR_W-1:0] addr_n;
  logic [DBE_W-1:0]  be_n;
  logic              ur_n;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign is_wr    = kind_is_write(in_kind);
  assign keep_be  = bm_en || !is_wr;

  for (genvar i = 0; i < DBE_W; i++) begin : g_lane
    assign be_n[i] = in_be[i] & keep_be;
  end

  always_comb begin
    if (bm_en) begin
      kind_n = in_kind;
      addr_n = in_addr;
      ur_n   = 1'b0;
    end else if (is_wr) begin
      kind_n = K_MEM_WR;
      addr_n = SINK_ADDR;
      ur_n   = 1'b0;
    end else begin
      kind_n = K_MEM_RD;
      addr_n = SINK_ADDR;
      ur_n   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_kind <= '0;
      out_addr <= '0;
      out_be   <= '0;
      out_data <= '0;
      out_tag  <= '0;
      out_ur   <= 1'b0;
    end else if (accept) begin
      out_kind <= kind_n;
      out_addr <= addr_n;
      out_be   <= be_n;
      out_data <= in_data;
      out_tag  <= in_tag;
      out_ur   <= ur_n;
    end
  end
endmodule

// File: rtl/bcg_decode.sv
module bcg_decode
  import bcg_pkg::*;
(
  input  cmd_bits_t cmd,
  input  logic      perr_detect,
  input  logic      mem_hit,
  input  logic      pmem_hit,
  input  logic      io_hit,
  output logic      perr_set,
  output logic      mem_claim,
  output logic      io_claim
);
  assign perr_set  = perr_detect && cmd.perr_en;
  assign mem_claim = (mem_hit || pmem_hit) && cmd.mem_en;
  assign io_claim  = io_hit && cmd.io_en;
endmodule

// File: rtl/bridge_cmd_gate.sv
module bridge_cmd_gate
  import bcg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  parameter int CFG_W  = 16,
  parameter logic [ADDR_W-1:0] SINK_ADDR = 'hC0000,
  localparam int DBE_W = DATA_W / 8,
  localparam int CBE_W = CFG_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CBE_W-1:0]  cfg_be,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              up_in_valid,
  output logic              up_in_ready,
  input  logic [2:0]        up_in_kind,
  input  logic [ADDR_W-1:0] up_in_addr,
  input  logic [DBE_W-1:0]  up_in_be,
  input  logic [DATA_W-1:0] up_in_data,
  input  logic [TAG_W-1:0]  up_in_tag,
  output logic              up_out_valid,
  input  logic              up_out_ready,
  output logic [2:0]        up_out_kind,
  output logic [ADDR_W-1:0] up_out_addr,
  output logic [DBE_W-1:0]  up_out_be,
  output logic [DATA_W-1:0] up_out_data,
  output logic [TAG_W-1:0]  up_out_tag,
  output logic              up_out_ur,
  input  logic              perr_detect,
  output logic              perr_set,
  input  logic              dn_mem_hit,
  input  logic              dn_pmem_hit,
  input  logic              dn_io_hit,
  output logic              dn_mem_claim,
  output logic              dn_io_claim
);
  cmd_bits_t cmd;

  bcg_cmd_reg #(.CFG_W(CFG_W)) reg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cmd_o     (cmd)
  );

  bcg_up_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .SINK_ADDR(SINK_ADDR)
  ) gate_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bm_en     (cmd.bm_en),
    .in_valid  (up_in_valid),
    .in_ready  (up_in_ready),
    .in_kind   (up_in_kind),
    .in_addr   (up_in_addr),
    .in_be     (up_in_be),
    .in_data   (up_in_data),
    .in_tag    (up_in_tag),
    .out_valid (up_out_valid),
    .out_ready (up_out_ready),
    .out_kind  (up_out_kind),
    .out_addr  (up_out_addr),
    .out_be    (up_out_be),
    .out_data  (up_out_data),
    .out_tag   (up_out_tag),
    .out_ur    (up_out_ur)
  );

  bcg_decode dec_i (
    .cmd         (cmd),
    .perr_detect (perr_detect),
    .mem_hit     (dn_mem_hit),
    .pmem_hit    (dn_pmem_hit),
    .io_hit      (dn_io_hit),
    .perr_set    (perr_set),
    .mem_claim   (dn_mem_claim),
    .io_claim    (dn_io_claim)
  );
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  parameter int CFG_W  = 16,
  parameter logic [ADDR_W-1:0] SINK_ADDR = 'hC0000,
  localparam int DBE_W = DATA_W / 8,
  localparam int CBE_W = CFG_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [CBE_W-1:0]  cfg_be,
  input logic [CFG_W-1:0]  cfg_wdata,
  input logic [CFG_W-1:0]  cfg_rdata,
  input logic              up_in_valid,
  input logic              up_in_ready,
  input logic [ADDR_W-1:0] up_in_addr,
  input logic              up_out_valid,
  input logic              up_out_ready,
  input logic [2:0]        up_out_kind,
  input logic [ADDR_W-1:0] up_out_addr,
  input logic [DBE_W-1:0]  up_out_be,
  input logic [DATA_W-1:0] up_out_data,
  input logic [TAG_W-1:0]  up_out_tag,
  input logic              up_out_ur,
  input logic              perr_set,
  input logic              dn_mem_claim,
  input logic              dn_io_claim
);
  logic acc;
  assign acc = up_in_valid && up_in_ready;

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_be[0] |=> cfg_rdata[6:0] == ($past(cfg_wdata[6:0]) & 7'h47)); // R2
  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_be[0]) |=> $stable(cfg_rdata)); // R2
  AST_PERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    perr_set |-> cfg_rdata[6]); // R4
  AST_MEM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dn_mem_claim |-> cfg_rdata[1]); // R8
  AST_IO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dn_io_claim |-> cfg_rdata[0]); // R9
  AST_PASS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cfg_rdata[2] |=> up_out_valid && up_out_addr == $past(up_in_addr) && !up_out_ur); // R5
  AST_SINK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cfg_rdata[2] |=> up_out_valid && up_out_addr == SINK_ADDR); // R6
  AST_UR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    up_out_valid && up_out_ur |-> up_out_kind == 3'd0 && up_out_addr == SINK_ADDR); // R7
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    up_out_valid && !up_out_ready |=> up_out_valid && $stable(up_out_kind) &&
      $stable(up_out_addr) && $stable(up_out_be) && $stable(up_out_data) &&
      $stable(up_out_tag) && $stable(up_out_ur)); // R11
endmodule

bind bridge_cmd_gate bcg_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .CFG_W(CFG_W), .SINK_ADDR(SINK_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .up_in_valid(up_in_valid), .up_in_ready(up_in_ready),
  .up_in_addr(up_in_addr), .up_out_valid(up_out_valid), .up_out_ready(up_out_ready),
  .up_out_kind(up_out_kind), .up_out_addr(up_out_addr), .up_out_be(up_out_be),
  .up_out_data(up_out_data), .up_out_tag(up_out_tag), .up_out_ur(up_out_ur),
  .perr_set(perr_set), .dn_mem_claim(dn_mem_claim), .dn_io_claim(dn_io_claim)
);

// File: tb/bridge_cmd_gate_tb_top.sv
`timescale 1ns/1ps
module bridge_cmd_gate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_wr = 0;
  logic [1:0]  cfg_be = 0;
  logic [15:0] cfg_wdata = 0;
  logic [15:0] cfg_rdata;
  logic        up_in_valid = 0, up_in_ready;
  logic [2:0]  up_in_kind = 0;
  logic [31:0] up_in_addr = 0;
  logic [3:0]  up_in_be = 0;
  logic [31:0] up_in_data = 0;
  logic [7:0]  up_in_tag = 0;
  logic        up_out_valid, up_out_ready = 0;
  logic [2:0]  up_out_kind;
  logic [31:0] up_out_addr;
  logic [3:0]  up_out_be;
  logic [31:0] up_out_data;
  logic [7:0]  up_out_tag;
  logic        up_out_ur;
  logic        perr_detect = 0, perr_set;
  logic        dn_mem_hit = 0, dn_pmem_hit = 0, dn_io_hit = 0;
  logic        dn_mem_claim, dn_io_claim;

  bridge_cmd_gate dut_i (.*);

  int errors = 0;
  int checks = 0;
  int ready_mode = 0;
  logic [6:0] cmd_m = '0;

  typedef struct {
    logic [79:0] fields;
    string       req;
  } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [79:0] model(logic [2:0] k, logic [31:0] a, logic [3:0] be,
                                        logic [31:0] d, logic [7:0] t, logic bme);
    logic wr;
    wr = (k == 3'd1) || (k == 3'd3) || (k == 3'd4) || (k == 3'd6);
    if (bme) return {k, a, be, d, t, 1'b0};
    if (wr) return {3'd1, 32'hC0000, 4'h0, d, t, 1'b0};
    return {3'd0, 32'hC0000, be, d, t, 1'b1};
  endfunction

  // monitor: drives ready, pops the scoreboard on each transfer
  always @(negedge clk) begin
    case (ready_mode)
      0: up_out_ready = 1'b1;
      1: up_out_ready = ($urandom_range(0, 2) != 0);
      default: up_out_ready = 1'b0;
    endcase
    #1;
    if (rst_n && up_out_valid && up_out_ready) begin
      logic [79:0] act;
      act = {up_out_kind, up_out_addr, up_out_be, up_out_data, up_out_tag, up_out_ur};
      if (sb.size() == 0) begin
        check(0, "R11", "unexpected output", act, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(act == e.fields, e.req, "forwarded request", act, e.fields);
      end
    end
  end

  task automatic send(input logic [2:0] k, input logic [31:0] a, input logic [3:0] be,
                      input logic [31:0] d, input logic [7:0] t, input string req);
    exp_t e;
    @(negedge clk);
    up_in_valid = 1; up_in_kind = k; up_in_addr = a; up_in_be = be;
    up_in_data = d; up_in_tag = t;
    #1;
    while (!up_in_ready) begin
      @(negedge clk);
      #1;
    end
    e.fields = model(k, a, be, d, t, cmd_m[2]);
    e.req = req;
    sb.push_back(e);
    @(posedge clk);
    #1 up_in_valid = 0;
  endtask

  task automatic cfg_write(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_be = be; cfg_wdata = d;
    @(posedge clk);
    #1 cfg_wr = 0;
    if (be[0]) cmd_m = d[6:0] & 7'h47;
  endtask

  task automatic check_reg(input string req);
    @(negedge clk); #1;
    check(cfg_rdata == {9'd0, cmd_m}, req, "register read", {64'd0, cfg_rdata}, {73'd0, cmd_m});
  endtask

  task automatic drain();
    ready_mode = 0;
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    @(negedge clk); #1;
    check(cfg_rdata == 16'h0, "R1", "reset read", {64'd0, cfg_rdata}, '0);
    check(!up_out_valid, "R1", "reset valid", {79'd0, up_out_valid}, '0);
    dn_mem_hit = 1; dn_io_hit = 1; #1;
    check(!dn_mem_claim && !dn_io_claim, "R1", "reset claims",
          {78'd0, dn_mem_claim, dn_io_claim}, '0);
    dn_mem_hit = 0; dn_io_hit = 0;

    // R2 R3 register writes
    cfg_write(2'b11, 16'hFFFF);
    check_reg("R3");
    check(cfg_rdata == 16'h0047, "R2", "write all ones", {64'd0, cfg_rdata}, 80'h47);
    cfg_write(2'b10, 16'h0000);
    check_reg("R2");
    cfg_write(2'b01, 16'h0038);
    check_reg("R3");
    check(cfg_rdata == 16'h0, "R3", "read-only bits", {64'd0, cfg_rdata}, '0);

    // R4 parity gating
    perr_detect = 1; #1;
    check(!perr_set, "R4", "disabled", {79'd0, perr_set}, '0);
    cfg_write(2'b01, 16'h0040);
    @(negedge clk); #1;
    check(perr_set, "R4", "enabled", {79'd0, perr_set}, 80'd1);
    perr_detect = 0; #1;
    check(!perr_set, "R4", "no error", {79'd0, perr_set}, '0);

    // R8 R9 claim gating
    dn_mem_hit = 1; dn_pmem_hit = 0; dn_io_hit = 1; #1;
    check(!dn_mem_claim, "R8", "mem disabled", {79'd0, dn_mem_claim}, '0);
    check(!dn_io_claim, "R9", "io disabled", {79'd0, dn_io_claim}, '0);
    cfg_write(2'b01, 16'h0002);
    @(negedge clk); dn_mem_hit = 0; dn_pmem_hit = 1; #1;
    check(dn_mem_claim, "R8", "prefetch hit", {79'd0, dn_mem_claim}, 80'd1);
    check(!dn_io_claim, "R9", "io still off", {79'd0, dn_io_claim}, '0);
    cfg_write(2'b01, 16'h0001);
    @(negedge clk); #1;
    check(!dn_mem_claim, "R8", "mem off again", {79'd0, dn_mem_claim}, '0);
    check(dn_io_claim, "R9", "io enabled", {79'd0, dn_io_claim}, 80'd1);
    dn_pmem_hit = 0; dn_io_hit = 0; #1;
    check(!dn_io_claim, "R9", "no hit", {79'd0, dn_io_claim}, '0);

    // R5 pass-through, every kind
    cfg_write(2'b01, 16'h0004);
    for (int k = 0; k < 7; k++)
      send(k[2:0], 32'h1000_0000 + k * 32'h40, 4'hF - k[3:0], 32'hA500_0000 + k, 8'(k), "R5");
    drain();

    // R6 R7 blocked, every kind
    cfg_write(2'b01, 16'h0000);
    for (int k = 0; k < 7; k++)
      send(k[2:0], 32'h2000_0000 + k, 4'hB, 32'h5A00_0000 + k, 8'(16 + k),
           ((k == 1) || (k == 3) || (k == 4) || (k == 6)) ? "R6" : "R7");
    drain();

    // R10 write in the acceptance cycle
    cfg_write(2'b01, 16'h0004);
    fork
      send(3'd1, 32'h3000_0000, 4'hF, 32'h1111_1111, 8'h30, "R10");
      cfg_write(2'b01, 16'h0000);
    join
    send(3'd0, 32'h3000_0010, 4'hF, 32'h2222_2222, 8'h31, "R10");
    drain();

    // R11 held request keeps its classification
    cfg_write(2'b01, 16'h0004);
    ready_mode = 2;
    send(3'd3, 32'h4000_0004, 4'h3, 32'h3333_3333, 8'h40, "R11");
    cfg_write(2'b01, 16'h0000);
    @(negedge clk); #1;
    check(up_out_valid && up_out_addr == 32'h4000_0004, "R11", "held under stall",
          {47'd0, up_out_valid, up_out_addr}, {47'd0, 1'b1, 32'h4000_0004});
    drain();

    // R11 random back-pressure with mode changes
    ready_mode = 1;
    for (int i = 0; i < 60; i++) begin
      if (i % 15 == 0) cfg_write(2'b01, (i % 30 == 0) ? 16'h0004 : 16'h0000);
      send($urandom_range(0, 6), $urandom, 4'($urandom), $urandom, 8'(i), "R11");
    end
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule